// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

The block holds three independent 16-bit down counters behind an 8-bit register port with a 2-bit address. Offsets 0, 1 and 2 reach the count registers of counters 0, 1 and 2, and offset 3 is a shared control register. A control word names one counter and sets how its count bytes are written and read, which of three waveform modes it runs, and whether it counts in binary or in four-digit BCD. A second form of the control word freezes a snapshot of a running count, so that software can read a consistent value while counting goes on.

Each counter has a count strobe input `cnt_tick` (one pulse per count period, sampled on `clk`), a gate input and an output. Mode 0 gives a single terminal-count event. Mode 2 gives a rate pulse one count period wide every N periods. Mode 3 gives a square wave with period N. Control word 0x37 followed by the count bytes 0x00 and 0x10 turns counter 0 into a BCD divide-by-1000 square-wave source.

Each counter steps through three states. CH_IDLE is entered on every accepted control word and waits for a count. CH_IDLE or CH_RUN goes to CH_ARMED when a count write completes. CH_ARMED goes to CH_RUN on the next count strobe, which loads the count. Two one-bit pointers, BY_LO and BY_HI, track the byte order. The write pointer moves to BY_HI after the low byte in two-byte access and back to BY_LO after the high byte. The read pointer does the same on reads. An accepted control word returns both pointers to BY_LO.

Top module: `tri_interval_timer`

## Requirements
- R1: After reset all three counter outputs are 0 and every counter is in CH_IDLE.
- R2: A write to offset 3 is a control word, and bits 7:6 name the counter (00, 01, 10). The value 11 in bits 7:6 makes the word have no effect on any counter.
- R3: Control bits 5:4 set the byte access: 01 = low byte only (high byte taken as 0), 10 = high byte only (low byte taken as 0), 11 = low byte then high byte. This order applies to both count writes and count reads at the counter's offset.
- R4: Control bits 3:1 set the mode: 000 = mode 0, x10 = mode 2, x11 = mode 3 (bit 3 is ignored). A word with 001, 100 or 101 in bits 3:1 has no effect.
- R5: Control bit 0 = 1 selects BCD counting (four decimal digits), and 0 selects binary.
- R6: A completed count write is loaded on the next count strobe, whatever the gate. After that, each strobe decrements the count only while the gate is 1.
- R7: Mode 0: the output goes to 0 when the control word is written and when a count is written. It goes to 1 on the strobe that brings the count to 0 (N strobes after the load) and stays at 1.
- R8: Mode 2: the output is 1, goes to 0 for one strobe period when the count reaches 1, then returns to 1 as the count reloads. The period is N strobes (N ≥ 2).
- R9: Mode 3: the output is 1 for ceil(N/2) strobes and 0 for floor(N/2) strobes, repeating with automatic reload (N ≥ 2).
- R10: A loaded count of 0 stands for 65536 in binary and 10000 in BCD.
- R11: Control bits 5:4 = 00 latch the named counter's current count. Reads then return the snapshot (two reads in two-byte access, one otherwise) while the counter keeps running. A second latch command before the snapshot has been read out has no effect.
- R12: A latch command and a count strobe in the same clock capture the count as it was before that strobe.
- R13: Control word 0x37 with count bytes 0x00, 0x10 makes counter 0 a BCD square wave with 500 strobes high and 500 low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs | input | 1 | Register port select |
| bus_wr | input | 1 | Write strobe, one clock per byte |
| bus_rd | input | 1 | Read strobe, one clock per byte; advances the byte pointer |
| bus_addr | input | 2 | Offset: 0..2 counters, 3 control register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed counter (0 at offset 3) |
| cnt_tick | input | 3 | Per-counter count strobe |
| cnt_gate | input | 3 | Per-counter gate; counting only while 1 |
| cnt_out | output | 3 | Per-counter waveform output |

## Verification
The two functions that can fall in the same clock are the snapshot capture of a latch command and the decrement caused by a count strobe on the same counter. The bench drives the control-register write of the latch command and that counter's strobe on one clock edge. It then expects the two-byte read to return the count from before the strobe, and a following live read to return the value one lower. This shows that the capture takes the registered count and not the decrementer's result.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        MD_TERM   = 2'd0,
        MD_RATE   = 2'd1,
        MD_SQUARE = 2'd2
    } tmr_mode_e;

    typedef enum logic [1:0] {
        AC_LATCH = 2'b00,
        AC_LO    = 2'b01,
        AC_HI    = 2'b10,
        AC_BOTH  = 2'b11
    } tmr_acc_e;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_ARMED = 2'd1,
        CH_RUN   = 2'd2
    } tmr_chst_e;

    typedef enum logic {
        BY_LO = 1'b0,
        BY_HI = 1'b1
    } tmr_byte_e;

endpackage

// File: rtl/tmr_decr.sv
module tmr_decr #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] val,
    input  logic             bcd,
    output logic [CNT_W-1:0] minus1,
    output logic [CNT_W-1:0] minus2
);
    localparam int DIGITS = CNT_W / 4;

    function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] v, input logic b);
        logic [CNT_W-1:0] r;
        logic             brw;
        if (!b) begin
            r = v - {{(CNT_W-1){1'b0}}, 1'b1};
        end else begin
            r   = v;
            brw = 1'b1;
            for (int d = 0; d < DIGITS; d++) begin
                if (brw) begin
                    if (v[d*4 +: 4] == 4'd0) begin
                        r[d*4 +: 4] = 4'd9;
                    end else begin
                        r[d*4 +: 4] = v[d*4 +: 4] - 4'd1;
                        brw = 1'b0;
                    end
                end
            end
        end
        return r;
    endfunction

    always_comb begin
        minus1 = step(val, bcd);
        minus2 = step(minus1, bcd);
    end

endmodule

// File: rtl/tmr_ctrl_decode.sv
module tmr_ctrl_decode
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [NUM_CH-1:0] prog,
    output logic [NUM_CH-1:0] latch,
    output logic [NUM_CH-1:0] cnt_wr,
    output tmr_mode_e         mode,
    output tmr_acc_e          acc,
    output logic              bcd
);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_CH);

    logic [ADDR_W-1:0] sel;
    logic [2:0]        mbits;
    logic              mode_ok;
    logic              ctrl_wr;

    always_comb begin
        sel     = wdata[DATA_W-1 -: ADDR_W];
        mbits   = wdata[3:1];
        acc     = tmr_acc_e'(wdata[5:4]);
        bcd     = wdata[0];
        ctrl_wr = wr_stb && (addr == CTRL_ADDR);
        mode_ok = (mbits == 3'b000) || mbits[1];
        if (mbits[1]) begin
            mode = mbits[0] ? MD_SQUARE : MD_RATE;
        end else begin
            mode = MD_TERM;
        end
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_strobe
        assign prog[ch]   = ctrl_wr && (sel == ADDR_W'(ch)) && (acc != AC_LATCH) && mode_ok;
        assign latch[ch]  = ctrl_wr && (sel == ADDR_W'(ch)) && (acc == AC_LATCH);
        assign cnt_wr[ch] = wr_stb && (addr == ADDR_W'(ch));
    end

    // R2: a control word naming the unused select value reaches no counter
    a_r2_illegal_select: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && (sel == {ADDR_W{1'b1}})) |-> ((prog == '0) && (latch == '0)));

    // R4: an unsupported mode code never programs a counter
    a_r4_bad_mode_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && (mbits inside {3'b001, 3'b100, 3'b101})) |-> (prog == '0));

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cw_prog,
    input  logic              cw_latch,
    input  tmr_mode_e         cw_mode,
    input  tmr_acc_e          cw_acc,
    input  logic              cw_bcd,
    input  logic              cnt_wr,
    input  logic              rd_stb,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tick,
    input  logic              gate,
    output logic              out,
    output logic [DATA_W-1:0] rbyte
);
    localparam logic [CNT_W-1:0] TWO = CNT_W'(2);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    tmr_chst_e         st_q, st_d;
    tmr_mode_e         mode_q;
    tmr_acc_e          acc_q;
    tmr_byte_e         wb_q, rb_q;
    logic              bcd_q;
    logic [CNT_W-1:0]  cnt_q, reload_q, lat_q, new_reload, even_reload, val;
    logic [CNT_W-1:0]  minus1, minus2;
    logic [DATA_W-1:0] lo_q;
    logic              out_q, phase_hi, lat_v;
    logic              cnt_done, load_now, count_now, sq_term;

    tmr_decr #(.CNT_W(CNT_W)) i_decr (
        .val    (cnt_q),
        .bcd    (bcd_q),
        .minus1 (minus1),
        .minus2 (minus2)
    );

    always_comb begin
        cnt_done    = cnt_wr && !cw_prog && ((acc_q != AC_BOTH) || (wb_q == BY_HI));
        load_now    = tick && (st_q == CH_ARMED) && !cnt_done;
        count_now   = tick && gate && (st_q == CH_RUN) && !cnt_done;
        even_reload = {reload_q[CNT_W-1:1], 1'b0};
        sq_term     = (phase_hi && reload_q[0]) ? (cnt_q == '0) : (cnt_q == TWO);
        unique case (acc_q)
            AC_LO:   new_reload = {{DATA_W{1'b0}}, wdata};
            AC_HI:   new_reload = {wdata, {DATA_W{1'b0}}};
            default: new_reload = {wdata, lo_q};
        endcase
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CH_IDLE:  if (cnt_done) st_d = CH_ARMED;
            CH_ARMED: if (tick && !cnt_done) st_d = CH_RUN;
            CH_RUN:   if (cnt_done) st_d = CH_ARMED;
            default:  st_d = CH_IDLE;
        endcase
        if (cw_prog) st_d = CH_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CH_IDLE;
        else        st_q <= st_d;
    end

    // datapath and output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= MD_TERM;
            acc_q    <= AC_BOTH;
            bcd_q    <= 1'b0;
            wb_q     <= BY_LO;
            rb_q     <= BY_LO;
            cnt_q    <= '0;
            reload_q <= '0;
            lat_q    <= '0;
            lo_q     <= '0;
            out_q    <= 1'b0;
            phase_hi <= 1'b1;
            lat_v    <= 1'b0;
        end else if (cw_prog) begin
            mode_q <= cw_mode;
            acc_q  <= cw_acc;
            bcd_q  <= cw_bcd;
            out_q  <= (cw_mode != MD_TERM);
            wb_q   <= BY_LO;
            rb_q   <= BY_LO;
            lat_v  <= 1'b0;
        end else begin
            if (cnt_wr) begin
                if ((acc_q == AC_BOTH) && (wb_q == BY_LO)) begin
                    lo_q <= wdata;
                    wb_q <= BY_HI;
                end else begin
                    wb_q     <= BY_LO;
                    reload_q <= new_reload;
                    if (mode_q == MD_TERM) out_q <= 1'b0;
                end
            end
            if (load_now) begin
                cnt_q    <= (mode_q == MD_SQUARE) ? even_reload : reload_q;
                phase_hi <= 1'b1;
                if (mode_q != MD_TERM) out_q <= 1'b1;
            end else if (count_now) begin
                unique case (mode_q)
                    MD_TERM: begin
                        cnt_q <= minus1;
                        if (minus1 == '0) out_q <= 1'b1;
                    end
                    MD_RATE: begin
                        if (cnt_q == ONE) begin
                            cnt_q <= reload_q;
                            out_q <= 1'b1;
                        end else begin
                            cnt_q <= minus1;
                            if (cnt_q == TWO) out_q <= 1'b0;
                        end
                    end
                    MD_SQUARE: begin
                        if (sq_term) begin
                            cnt_q    <= even_reload;
                            phase_hi <= !phase_hi;
                            out_q    <= !phase_hi;
                        end else begin
                            cnt_q <= minus2;
                        end
                    end
                    default: cnt_q <= cnt_q;
                endcase
            end
            if (rd_stb) begin
                if ((acc_q == AC_BOTH) && (rb_q == BY_LO)) begin
                    rb_q <= BY_HI;
                end else begin
                    rb_q  <= BY_LO;
                    lat_v <= 1'b0;
                end
            end
            if (cw_latch && !lat_v) begin
                lat_v <= 1'b1;
                lat_q <= cnt_q;
            end
        end
    end

    // read byte selection
    always_comb begin
        val = lat_v ? lat_q : cnt_q;
        unique case (acc_q)
            AC_HI:   rbyte = val[CNT_W-1 -: DATA_W];
            AC_BOTH: rbyte = (rb_q == BY_HI) ? val[CNT_W-1 -: DATA_W] : val[DATA_W-1:0];
            default: rbyte = val[DATA_W-1:0];
        endcase
    end

    assign out = out_q;

    // R6: with the gate low a running count does not move
    a_r6_gate_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == CH_RUN) && !gate) |=> $stable(cnt_q));

    // R7: in mode 0 the output only rises when the count has reached zero
    a_r7_term_rise: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q == MD_TERM) && $rose(out_q)) |-> (cnt_q == '0));

    // R8: the mode 2 low pulse ends on the next counting strobe
    a_r8_pulse_one_period: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q == MD_RATE) && (st_q == CH_RUN) && !out_q && count_now && !cw_prog) |=> out_q);

    // R9: a running mode 3 count always stays even
    a_r9_square_even: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q == MD_SQUARE) && (st_q == CH_RUN)) |-> !cnt_q[0]);

    // R11: a held snapshot is kept until it has been read out
    a_r11_latch_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_v && !rd_stb && !cw_prog) |=> (lat_v && $stable(lat_q)));

endmodule

// File: rtl/tri_interval_timer.sv
module tri_interval_timer
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cs,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_CH-1:0] cnt_tick,
    input  logic [NUM_CH-1:0] cnt_gate,
    output logic [NUM_CH-1:0] cnt_out
);
    logic [NUM_CH-1:0] prog_v, latch_v, cntwr_v, rd_v;
    tmr_mode_e         cw_mode;
    tmr_acc_e          cw_acc;
    logic              cw_bcd;
    logic [DATA_W-1:0] rbyte [NUM_CH];

    tmr_ctrl_decode #(
        .NUM_CH (NUM_CH),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) i_decode (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_stb (bus_cs && bus_wr),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .prog   (prog_v),
        .latch  (latch_v),
        .cnt_wr (cntwr_v),
        .mode   (cw_mode),
        .acc    (cw_acc),
        .bcd    (cw_bcd)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        assign rd_v[ch] = bus_cs && bus_rd && (bus_addr == ADDR_W'(ch));

        tmr_channel #(
            .CNT_W  (CNT_W),
            .DATA_W (DATA_W)
        ) i_channel (
            .clk      (clk),
            .rst_n    (rst_n),
            .cw_prog  (prog_v[ch]),
            .cw_latch (latch_v[ch]),
            .cw_mode  (cw_mode),
            .cw_acc   (cw_acc),
            .cw_bcd   (cw_bcd),
            .cnt_wr   (cntwr_v[ch]),
            .rd_stb   (rd_v[ch]),
            .wdata    (bus_wdata),
            .tick     (cnt_tick[ch]),
            .gate     (cnt_gate[ch]),
            .out      (cnt_out[ch]),
            .rbyte    (rbyte[ch])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (bus_addr == ADDR_W'(c)) bus_rdata = rbyte[c];
        end
    end

    // R2: at most one counter is touched by any bus write
    a_r2_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(prog_v | latch_v | cntwr_v));

endmodule

// File: tb/test_tri_interval_timer.sv
module test_tri_interval_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 1'b0, wr = 1'b0, rd = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic [2:0] tick = 3'b000;
    logic [2:0] gate = 3'b111;
    logic [2:0] out;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    tri_interval_timer i_tri_interval_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_cs    (cs),
        .bus_wr    (wr),
        .bus_rd    (rd),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .cnt_tick  (tick),
        .cnt_gate  (gate),
        .cnt_out   (out)
    );

    // {sel[2], mode[3], bcd, pad[2], lo[8], hi[8], n[16]}
    localparam logic [39:0] VECS [0:8] = '{
        {2'd0, 3'b011, 1'b0, 2'b00, 8'h06, 8'h00, 16'd6},
        {2'd1, 3'b011, 1'b0, 2'b00, 8'h07, 8'h00, 16'd7},
        {2'd2, 3'b010, 1'b0, 2'b00, 8'h05, 8'h00, 16'd5},
        {2'd0, 3'b111, 1'b0, 2'b00, 8'h09, 8'h00, 16'd9},
        {2'd1, 3'b110, 1'b1, 2'b00, 8'h12, 8'h00, 16'd12},
        {2'd2, 3'b000, 1'b0, 2'b00, 8'h09, 8'h00, 16'd9},
        {2'd0, 3'b000, 1'b1, 2'b00, 8'h15, 8'h00, 16'd15},
        {2'd0, 3'b011, 1'b1, 2'b00, 8'h00, 8'h10, 16'd1000},
        {2'd1, 3'b010, 1'b0, 2'b00, 8'h00, 8'h01, 16'd256}
    };

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cs = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        cs = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output int d);
        @(negedge clk);
        cs = 1'b1; rd = 1'b1; addr = a;
        #1 d = int'(rdata);
        @(negedge clk);
        cs = 1'b0; rd = 1'b0;
    endtask

    task automatic pulse(input int ch, input int count);
        for (int i = 0; i < count; i++) begin
            @(negedge clk);
            tick[ch] = 1'b1;
            @(negedge clk);
            tick[ch] = 1'b0;
        end
    endtask

    task automatic run_until(input int ch, input logic level, input int lim, output int n);
        n = 0;
        do begin
            pulse(ch, 1);
            n++;
        end while ((out[ch] != level) && (n < lim));
    endtask

    initial begin
        int rv, hl, ll;
        logic [1:0] s;
        logic [2:0] m;
        logic b;
        int nv;
        string tag;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 outputs after reset", int'(out), 0);
        bus_read(2'd3, rv);
        check("R1 control offset reads 0", rv, 0);

        // vector table walk
        for (int v = 0; v < 9; v++) begin
            s  = VECS[v][39:38];
            m  = VECS[v][37:35];
            b  = VECS[v][34];
            nv = int'(VECS[v][15:0]);
            tag = $sformatf("vec%0d %s%s%s%s", v,
                            (m == 3'b000) ? "R7" : (m[1:0] == 2'b10) ? "R8" : "R9",
                            b ? " R5" : "", m[2] ? " R4" : "",
                            ({s, 2'b11, m, b} == 8'h37) ? " R13" : "");
            bus_write(2'd3, {s, 2'b11, m, b});
            if (m == 3'b000) check({tag, " low after control word"}, int'(out[s]), 0);
            bus_write(s, VECS[v][31:24]);
            bus_write(s, VECS[v][23:16]);
            pulse(int'(s), 1); // R6 load strobe
            if (m == 3'b000) begin
                pulse(int'(s), nv - 1);
                check({tag, " still low one strobe before zero"}, int'(out[s]), 0);
                pulse(int'(s), 1);
                check({tag, " high at zero"}, int'(out[s]), 1);
                pulse(int'(s), 2);
                check({tag, " stays high"}, int'(out[s]), 1);
            end else if (m[1:0] == 2'b10) begin
                pulse(int'(s), nv - 2);
                check({tag, " high before pulse"}, int'(out[s]), 1);
                pulse(int'(s), 1);
                check({tag, " low pulse"}, int'(out[s]), 0);
                pulse(int'(s), 1);
                check({tag, " pulse one period"}, int'(out[s]), 1);
                pulse(int'(s), nv - 1);
                check({tag, " next pulse after period"}, int'(out[s]), 0);
            end else begin
                run_until(int'(s), 1'b0, nv + 4, hl);
                check({tag, " high length"}, hl, (nv + 1) / 2);
                run_until(int'(s), 1'b1, nv + 4, ll);
                check({tag, " low length"}, ll, nv / 2);
                run_until(int'(s), 1'b0, nv + 4, hl);
                check({tag, " high length after reload"}, hl, (nv + 1) / 2);
            end
        end

        // R2: select value 11 touches no counter (counter 1 rate high, counter 2 term high)
        pulse(1, 1);
        check("R2 precondition counter 1 high", int'(out[1]), 1);
        bus_write(2'd3, 8'hF0);
        check("R2 select 11 leaves counter 1", int'(out[1]), 1);
        check("R2 select 11 leaves counter 2", int'(out[2]), 1);
        // R4: mode code 001 is ignored
        bus_write(2'd3, 8'hB2);
        check("R4 mode 001 ignored on counter 2", int'(out[2]), 1);
        bus_write(2'd3, 8'hB8); // mode code 100
        check("R4 mode 100 ignored on counter 2", int'(out[2]), 1);

        // R10: binary zero count acts as 65536
        bus_write(2'd3, 8'h30);
        bus_write(2'd0, 8'h00);
        bus_write(2'd0, 8'h00);
        pulse(0, 2);
        check("R10 binary zero not terminal", int'(out[0]), 0);
        bus_write(2'd3, 8'h00);
        bus_read(2'd0, rv);
        check("R10 binary wrap low byte", rv, 8'hFF);
        bus_read(2'd0, rv);
        check("R10 binary wrap high byte", rv, 8'hFF);

        // R10: BCD zero count acts as 10000
        bus_write(2'd3, 8'h71);
        bus_write(2'd1, 8'h00);
        bus_write(2'd1, 8'h00);
        pulse(1, 1);
        pulse(1, 9999);
        check("R10 BCD 9999 strobes still low", int'(out[1]), 0);
        pulse(1, 1);
        check("R10 BCD 10000 strobes high", int'(out[1]), 1);

        // R6: gate low holds the count
        bus_write(2'd3, 8'h90);
        bus_write(2'd2, 8'h04);
        gate[2] = 1'b0;
        pulse(2, 1);
        pulse(2, 5);
        check("R6 gate low output held", int'(out[2]), 0);
        bus_write(2'd3, 8'h80);
        bus_read(2'd2, rv);
        check("R6 gate low count held", rv, 4);
        gate[2] = 1'b1;
        pulse(2, 3);
        check("R6 gate high counting resumes", int'(out[2]), 0);
        pulse(2, 1);
        check("R6 terminal after gate restored", int'(out[2]), 1);

        // R3: low-byte-only access
        bus_write(2'd3, 8'h94);
        bus_write(2'd2, 8'h0A);
        pulse(2, 4);
        bus_write(2'd3, 8'h80);
        bus_read(2'd2, rv);
        check("R3 low-byte-only read", rv, 7);
        // R3: high-byte-only access
        bus_write(2'd3, 8'hA4);
        bus_write(2'd2, 8'h02);
        pulse(2, 2);
        bus_write(2'd3, 8'h80);
        bus_read(2'd2, rv);
        check("R3 high-byte-only read", rv, 1);

        // R11: latch snapshot while counting
        bus_write(2'd3, 8'h74);
        bus_write(2'd1, 8'h00);
        bus_write(2'd1, 8'h03);
        pulse(1, 1);
        pulse(1, 5);
        bus_write(2'd3, 8'h40);
        pulse(1, 3);
        bus_read(2'd1, rv);
        check("R11 snapshot low byte", rv, 8'hFB);
        bus_read(2'd1, rv);
        check("R11 snapshot high byte", rv, 8'h02);
        bus_read(2'd1, rv);
        check("R11 live low byte after release", rv, 8'hF8);
        bus_read(2'd1, rv);
        check("R11 live high byte after release", rv, 8'h02);
        bus_write(2'd3, 8'h40);
        pulse(1, 1);
        bus_write(2'd3, 8'h40);
        bus_read(2'd1, rv);
        check("R11 second latch ignored", rv, 8'hF8);
        bus_read(2'd1, rv);
        check("R11 second latch high byte", rv, 8'h02);

        // R12: latch command and strobe on the same edge
        @(negedge clk);
        cs = 1'b1; wr = 1'b1; addr = 2'd3; wdata = 8'h40; tick[1] = 1'b1;
        @(negedge clk);
        cs = 1'b0; wr = 1'b0; tick[1] = 1'b0;
        bus_read(2'd1, rv);
        check("R12 snapshot is pre-strobe count", rv, 8'hF7);
        bus_read(2'd1, rv);
        check("R12 snapshot high byte", rv, 8'h02);
        bus_read(2'd1, rv);
        check("R12 live count took the strobe", rv, 8'hF6);
        bus_read(2'd1, rv);
        check("R12 live high byte", rv, 8'h02);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule